// File: doc/BRIEF.md
# Cacheability Indicator Output Control

This block produces a processor's active-low cacheability indication together with the enable for its tristate driver. In write-back operation it reports two things to the system. The first is whether the current read is allowed to fill a cache line. The second is whether the current cycle moves a modified line out, either as a burst write-back or as a copy-back. In write-through operation the indicator is never driven.

The indication is decided in the clock where the address strobe appears. It is then held through the whole bus cycle, up to and including the clock where ready or burst-ready is seen. A bus back-off or hold request releases the driver at once. The decision of an interrupted cycle is kept, so the indication returns when the bus is granted back and when the cycle is restarted. The block also gives a qualified line-fill permission. This is the indication combined with the external cache-enable input on the ready clock of a read.

Top module: `cache_ind_ctrl`

## Requirements
- R1: When `wb_mode_i` is 0 (write-through), `cind_oe_o` is 0 in every cycle.
- R2: In any cycle where `backoff_i` or `hold_i` is 1, `cind_oe_o` is 0 and `fill_ok_o` is 0.
- R3: While `rst_n` is low, and for the first two rising clock edges after its release, `cind_oe_o` is 0.
- R4: With write-back mode and `cyc_type_i` = 1 (read), the indication is asserted (`cind_n_o` = 0) when `cacheable_i` is 1, and is not asserted when it is 0.
- R5: With write-back mode and `cyc_type_i` = 2 (burst write-back) or 3 (copy-back), the indication is asserted whatever `cacheable_i` is.
- R6: With `cyc_type_i` = 0 (other), the indication is not asserted. Whenever the driver is enabled and the indication is not asserted, `cind_n_o` is 1.
- R7: The indication takes its new value in the same clock in which `addr_strobe_i` is 1. There is no register delay.
- R8: Once asserted, the indication stays asserted through the clock in which `rdy_i` or `brdy_i` is 1. It is not asserted in the following clock unless a new strobe asserts it again.
- R9: `fill_ok_o` is 1 only in a ready clock of a read cycle whose indication is asserted while `cen_i` is 1. A read with the indication not asserted never gives `fill_ok_o`, even with `cen_i` at 1.
- R10: A back-off or hold in mid-cycle keeps the cycle's decision, and a ready seen while floating is ignored. After release the indication is asserted again, and a restarting strobe asserts it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode_i | input | 1 | 1 = write-back, 0 = write-through |
| cyc_type_i | input | 2 | 0 other, 1 read, 2 burst write-back, 3 copy-back |
| cacheable_i | input | 1 | Internal cacheable decision for a read |
| addr_strobe_i | input | 1 | Address strobe, active high |
| rdy_i | input | 1 | Non-burst ready, active high |
| brdy_i | input | 1 | Burst ready, active high |
| backoff_i | input | 1 | Bus back-off request, active high |
| hold_i | input | 1 | Bus hold request, active high |
| cen_i | input | 1 | External cache-enable, active high |
| cind_n_o | output | 1 | Cacheability indicator pin level, active low |
| cind_oe_o | output | 1 | Tristate enable for the indicator pin |
| fill_ok_o | output | 1 | Qualified line-fill permission |

## Verification
The bench sweeps every combination of mode, cycle type, cacheable decision and cache-enable. For each one it checks the pin in the strobe clock, in a wait clock, in the ready clock and in the clock after it. A design that registered the strobe decision would show the pin one clock late. A design that cleared the indication on the ready edge would drop it during the ready clock, and so would lose the fill permission. A separate run applies back-off and hold in mid-cycle, including a ready during the float. A design that dropped its state there would fail to reassert after release, and one that honoured that ready would end the cycle early. The reset check catches a driver that is enabled before the reset synchroniser has released.

// File: rtl/cind_pkg.sv
package cind_pkg;
  typedef enum logic [1:0] {
    CYC_OTHER = 2'd0,
    CYC_READ  = 2'd1,
    CYC_BWB   = 2'd2,
    CYC_CPB   = 2'd3
  } cyc_e;
endpackage

// File: rtl/cind_rst_sync.sv
module cind_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[STAGES-1];
endmodule

// File: rtl/cind_qual.sv
module cind_qual
  import cind_pkg::*;
(
  input  logic wb_mode_i,
  input  cyc_e cyc_i,
  input  logic cacheable_i,
  output logic qual_o,
  output logic is_read_o
);
  always_comb begin
    is_read_o = (cyc_i == CYC_READ);
    unique case (cyc_i)
      CYC_READ: qual_o = wb_mode_i & cacheable_i;
      CYC_BWB,
      CYC_CPB:  qual_o = wb_mode_i;
      default:  qual_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cind_track.sv
module cind_track (
  input  logic clk,
  input  logic rst_n,
  input  logic float_i,
  input  logic strobe_i,
  input  logic done_i,
  input  logic qual_i,
  input  logic is_read_i,
  output logic asserted_o,
  output logic read_o
);
  logic act_q, act_d;
  logic rd_q, rd_d;

  always_comb begin
    act_d      = act_q;
    rd_d       = rd_q;
    asserted_o = 1'b0;
    read_o     = rd_q;
    if (!float_i) begin
      if (strobe_i) begin
        asserted_o = qual_i;
        read_o     = is_read_i;
        act_d      = qual_i;
        rd_d       = is_read_i;
      end else begin
        asserted_o = act_q;
        if (done_i) act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      rd_q  <= rd_d;
    end
  end
endmodule

// File: rtl/cache_ind_ctrl.sv
module cache_ind_ctrl
  import cind_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wb_mode_i,
  input  logic [1:0] cyc_type_i,
  input  logic       cacheable_i,
  input  logic       addr_strobe_i,
  input  logic       rdy_i,
  input  logic       brdy_i,
  input  logic       backoff_i,
  input  logic       hold_i,
  input  logic       cen_i,
  output logic       cind_n_o,
  output logic       cind_oe_o,
  output logic       fill_ok_o
);
  logic rst_n_sync;
  logic drive, qual, is_read, asserted, cyc_read, done;

  cind_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_sync)
  );

  cind_qual u_qual (
    .wb_mode_i   (wb_mode_i),
    .cyc_i       (cyc_e'(cyc_type_i)),
    .cacheable_i (cacheable_i),
    .qual_o      (qual),
    .is_read_o   (is_read)
  );

  assign drive = rst_n_sync & wb_mode_i & ~(backoff_i | hold_i);
  assign done  = rdy_i | brdy_i;

  cind_track u_track (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .float_i    (~drive),
    .strobe_i   (addr_strobe_i),
    .done_i     (done),
    .qual_i     (qual),
    .is_read_i  (is_read),
    .asserted_o (asserted),
    .read_o     (cyc_read)
  );

  assign cind_oe_o = drive;
  assign cind_n_o  = ~asserted;
  assign fill_ok_o = asserted & cyc_read & cen_i & done;
endmodule

// File: rtl/cache_ind_ctrl_chk.sv
module cache_ind_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wb_mode_i,
  input logic addr_strobe_i,
  input logic rdy_i,
  input logic brdy_i,
  input logic backoff_i,
  input logic hold_i,
  input logic cen_i,
  input logic cind_n_o,
  input logic cind_oe_o,
  input logic fill_ok_o
);
  // R1
  wt_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_mode_i |-> !cind_oe_o);

  // R2
  req_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (backoff_i || hold_i) |-> (!cind_oe_o && !fill_ok_o));

  // R9
  fill_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ok_o |-> (!cind_n_o && cen_i && cind_oe_o && (rdy_i || brdy_i)));

  // R8
  end_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cind_oe_o && !cind_n_o && (rdy_i || brdy_i) && !addr_strobe_i)
      |=> (addr_strobe_i || cind_n_o));

  // R8
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cind_oe_o && !cind_n_o && !rdy_i && !brdy_i)
      |=> (!cind_oe_o || addr_strobe_i || !cind_n_o));
endmodule

bind cache_ind_ctrl cache_ind_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wb_mode_i     (wb_mode_i),
  .addr_strobe_i (addr_strobe_i),
  .rdy_i         (rdy_i),
  .brdy_i        (brdy_i),
  .backoff_i     (backoff_i),
  .hold_i        (hold_i),
  .cen_i         (cen_i),
  .cind_n_o      (cind_n_o),
  .cind_oe_o     (cind_oe_o),
  .fill_ok_o     (fill_ok_o)
);

// File: tb/cache_ind_ctrl_tb.sv
module cache_ind_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic       wb_mode;
  logic [1:0] cyc_type;
  logic       cacheable, strobe, rdy, brdy, backoff, hold, cen;
  logic       cind_n, cind_oe, fill_ok;
  int         checks;
  int         errors;

  cache_ind_ctrl u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .wb_mode_i     (wb_mode),
    .cyc_type_i    (cyc_type),
    .cacheable_i   (cacheable),
    .addr_strobe_i (strobe),
    .rdy_i         (rdy),
    .brdy_i        (brdy),
    .backoff_i     (backoff),
    .hold_i        (hold),
    .cen_i         (cen),
    .cind_n_o      (cind_n),
    .cind_oe_o     (cind_oe),
    .fill_ok_o     (fill_ok)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #5;
  endtask

  task automatic idle();
    strobe = 0; rdy = 0; brdy = 0; backoff = 0; hold = 0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 0; wb_mode = 1; cyc_type = 2'd1; cacheable = 1; cen = 1;
    idle();
    step();
    chk("R3 oe in reset", cind_oe, 1'b0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #5;
    chk("R3 oe after one edge", cind_oe, 1'b0);
    @(posedge clk); #5;
    chk("R3 oe after two edges", cind_oe, 1'b1);
    step();

    for (int m = 0; m < 2; m++)
      for (int t = 0; t < 4; t++)
        for (int c = 0; c < 2; c++)
          for (int e = 0; e < 2; e++)
            for (int b = 0; b < 2; b++) begin
              logic q;
              wb_mode = m[0]; cyc_type = t[1:0]; cacheable = c[0]; cen = e[0];
              q = m[0] & ((t == 1 && c == 1) || t == 2 || t == 3);
              @(negedge clk); idle(); strobe = 1; #5;
              chk(m[0] ? "R1 oe in write-back" : "R1 oe in write-through", cind_oe, m[0]);
              if (m[0]) chk(t == 1 ? "R4 strobe clock" : (t == 0 ? "R6 strobe clock" : "R5 strobe clock"), cind_n, ~q);
              if (m[0]) chk("R7 same clock as strobe", cind_n, ~q);
              @(negedge clk); idle(); #5;
              if (m[0]) chk("R8 wait clock", cind_n, ~q);
              chk("R9 no fill before ready", fill_ok, 1'b0);
              @(negedge clk); idle(); if (b) brdy = 1; else rdy = 1; #5;
              if (m[0]) chk("R8 ready clock", cind_n, ~q);
              chk("R9 fill on ready", fill_ok, q & (t == 1) & e[0]);
              @(negedge clk); idle(); #5;
              if (m[0]) chk("R8 after ready", cind_n, 1'b1);
              chk("R9 no fill after ready", fill_ok, 1'b0);
            end

    for (int f = 0; f < 2; f++) begin
      wb_mode = 1; cyc_type = 2'd1; cacheable = 1; cen = 1;
      @(negedge clk); idle(); strobe = 1; #5;
      chk("R10 strobe asserts", cind_n, 1'b0);
      @(negedge clk); idle(); if (f) hold = 1; else backoff = 1; #5;
      chk("R2 float oe", cind_oe, 1'b0);
      chk("R2 float fill", fill_ok, 1'b0);
      @(negedge clk); if (f) hold = 1; else backoff = 1; rdy = 1; #5;
      chk("R2 float with ready", cind_oe, 1'b0);
      chk("R2 no fill in float", fill_ok, 1'b0);
      @(negedge clk); idle(); #5;
      chk("R10 kept after release", cind_n, 1'b0);
      chk("R10 oe after release", cind_oe, 1'b1);
      @(negedge clk); idle(); strobe = 1; #5;
      chk("R10 restart asserts", cind_n, 1'b0);
      @(negedge clk); idle(); brdy = 1; #5;
      chk("R10 fill after restart", fill_ok, 1'b1);
      @(negedge clk); idle(); #5;
      chk("R8 released after restart", cind_n, 1'b1);
    end

    @(negedge clk); idle(); wb_mode = 0; cyc_type = 2'd3; strobe = 1; #5;
    chk("R1 write-through copy-back", cind_oe, 1'b0);
    @(negedge clk); idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule